// File: doc/BRIEF.md
# Compare-Match Timer with Pulse/Toggle Output

A 32-bit up-counting timer driven from a simple word-addressed register port. The counter advances every clock, or once every 2^(n+1) clocks when the prescaler is enabled. At the top of its range it either reloads from a load register and keeps running, or stops at zero. A compare unit raises a match event when the counting value steps onto a programmed match value.

Overflow and match events can drive a single output pin, either toggling it or giving it a one-cycle pulse, and they feed an interrupt status register. A status bit can only be set while its interrupt enable is set. The wakeup pulse uses a separate enable and ignores the interrupt mask. A capture event arrives from outside as a one-cycle strobe and is handled only by the interrupt logic. A soft-reset bit in the configuration register returns all state to its power-on values.

Register word addresses are: 0x0 identification, 0x1 configuration, 0x2 reset status, 0x3 interrupt status, 0x4 interrupt enable, 0x5 wakeup enable, 0x6 control, 0x7 count, 0x8 load, 0x9 trigger, 0xA match, 0xB posted mode. Reads are combinational from `addr_i`. A write takes effect at the clock edge where `we_i` is high.

Top module: `cmp_timer`

## Requirements
- R1: After rst_ni, these reads return 0: control, count, load, match, status and both enables. Identification reads 0x21, reset status reads 1, trigger reads 0xFFFFFFFF, posted mode (0xB) reads 0x4. irq_o and pin_o are 0 and pin_oe_o is 1.
- R2: While control bit0 (start) is 1 and the prescaler is off, the count rises by one on every clock. A count write (0x7) loads its value at that write's edge, and counting resumes from it on the following edge.
- R3: With control bit5 set, the count advances once every 2^(v+1) clocks, where v is control bits 4:2. The first advance comes 2^(v+1) clocks after the start edge.
- R4: A step from 0xFFFFFFFF is an overflow event. If control bit1 (auto-reload) is set, the count becomes the load value (0x8) and start stays 1. If it is clear, the count becomes 0 and start clears.
- R5: With control bit6 set, a match event fires when the count steps onto the match value (0xA).
- R6: Control bits 11:10 select the trigger mode: 0 gives no pin events, 1 uses overflow, 2 uses overflow and match. With control bit12 set, each event inverts the pin. With it clear, each event inverts the pin for exactly one cycle.
- R7: One edge after start is 0 or trigger mode is 0, the pin takes control bit7. pin_oe_o is the inverse of control bit14.
- R8: Status bit0 is match, bit1 is overflow and bit2 is capture. An event sets its bit only if the same bit of the interrupt enable is 1. irq_o is high while any status bit is set. Writing 1 to a status bit clears it.
- R9: wake_o pulses high for one cycle after any event whose wakeup-enable bit is 1, whatever the interrupt enable.
- R10: A write to the trigger register (0x9) loads the count from the load register.
- R11: A configuration write with bit1 set resets every register to 0 and the posted bit to 1. Otherwise the configuration register keeps only the bits in mask 0x33D.
- R12: The cycle of a count or trigger write generates no overflow and no match event, even if the old count was at the top of its range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Functional clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| cap_evt_i | input | 1 | Capture event strobe |
| irq_o | output | 1 | Interrupt line |
| wake_o | output | 1 | Wakeup pulse |
| pin_o | output | 1 | Timer output pin value |
| pin_oe_o | output | 1 | Output pin drive enable |

## Verification
Every event is a combinational decode in the cycle before the edge that moves the count. Status, wakeup and pin therefore change at that same edge. If a count write places the count three steps below the target, the result is due three edges after the write edge. The bench counts whole edges from each write edge with negedge waits and samples in the low phase. Prescaler results are due at floor(k / 2^(v+1)) for k edges after the start edge, and random divisor and wait pairs are checked against that formula.

// File: rtl/cmp_timer_pkg.sv
`timescale 1ns/1ps
package cmp_timer_pkg;
  typedef enum logic [1:0] {
    TRIG_NONE = 2'd0,
    TRIG_OVF  = 2'd1,
    TRIG_BOTH = 2'd2,
    TRIG_RSVD = 2'd3
  } trig_mode_e;

  typedef struct packed {
    logic       pin_in;
    logic       cap_second;
    logic       toggle;
    trig_mode_e trig;
    logic [1:0] cap_edge;
    logic       dflt;
    logic       cmp_en;
    logic       pre_en;
    logic [2:0] pre_val;
    logic       reload;
    logic       run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam int N_EV   = 3;
  localparam int EV_MAT = 0;
  localparam int EV_OVF = 1;
  localparam int EV_CAP = 2;

  localparam logic [3:0] A_ID    = 4'h0;
  localparam logic [3:0] A_CFG   = 4'h1;
  localparam logic [3:0] A_RSTS  = 4'h2;
  localparam logic [3:0] A_STAT  = 4'h3;
  localparam logic [3:0] A_IEN   = 4'h4;
  localparam logic [3:0] A_WEN   = 4'h5;
  localparam logic [3:0] A_CTRL  = 4'h6;
  localparam logic [3:0] A_CNT   = 4'h7;
  localparam logic [3:0] A_LOAD  = 4'h8;
  localparam logic [3:0] A_TRIG  = 4'h9;
  localparam logic [3:0] A_MATCH = 4'hA;
  localparam logic [3:0] A_POST  = 4'hB;
endpackage

// File: rtl/cmp_timer_presc.sv
`timescale 1ns/1ps
module cmp_timer_presc #(
  parameter int PS_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            srst_i,
  input  logic            run_i,
  input  logic            en_i,
  input  logic [PS_W-1:0] sel_i,
  output logic            tick_o
);
  localparam int DIV_W = 1 << PS_W;

  logic [DIV_W-1:0] div_q, lim;

  always_comb begin
    for (int i = 0; i < DIV_W; i++) lim[i] = (i <= int'(sel_i));
  end

  assign tick_o = run_i & (~en_i | (div_q == lim));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        div_q <= '0;
    else if (srst_i || !run_i || !en_i) div_q <= '0;
    else if (tick_o)                    div_q <= '0;
    else                                div_q <= div_q + 1'b1;
  end

  // divided ticks are never back to back
  p_presc_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && en_i && !srst_i) |=> (!tick_o || !en_i));
endmodule

// File: rtl/cmp_timer_cnt.sv
`timescale 1ns/1ps
module cmp_timer_cnt #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         srst_i,
  input  logic         tick_i,
  input  logic         reload_en_i,
  input  logic         cmp_en_i,
  input  logic         wr_i,
  input  logic [W-1:0] wr_val_i,
  input  logic         trig_i,
  input  logic [W-1:0] load_i,
  input  logic [W-1:0] match_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o,
  output logic         match_o
);
  logic [W-1:0] cnt_q, nxt;
  logic         busy, at_max;

  assign busy    = wr_i | trig_i | srst_i;
  assign at_max  = &cnt_q;
  assign nxt     = cnt_q + 1'b1;
  assign ovf_o   = tick_i & ~busy & at_max;
  assign match_o = tick_i & ~busy & ~at_max & cmp_en_i & (nxt == match_i);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (srst_i)  cnt_q <= '0;
    else if (wr_i)    cnt_q <= wr_val_i;
    else if (trig_i)  cnt_q <= load_i;
    else if (ovf_o)   cnt_q <= reload_en_i ? load_i : '0;
    else if (tick_i)  cnt_q <= nxt;
  end

  p_wr_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !srst_i) |=> cnt_o == $past(wr_val_i));
  p_wrap_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !reload_en_i) |=> cnt_o == '0);
  p_wrap_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && reload_en_i) |=> cnt_o == $past(load_i));
  p_quiet_write_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i || trig_i) |-> !(ovf_o || match_o));
endmodule

// File: rtl/cmp_timer_pin.sv
`timescale 1ns/1ps
module cmp_timer_pin
  import cmp_timer_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       srst_i,
  input  logic       run_i,
  input  trig_mode_e mode_i,
  input  logic       toggle_i,
  input  logic       dflt_i,
  input  logic       ovf_i,
  input  logic       match_i,
  output logic       pin_o
);
  logic lvl_q, pulse_q, use_ovf, fire, idle;

  assign use_ovf = (mode_i == TRIG_OVF) | (mode_i == TRIG_BOTH);
  assign fire    = (use_ovf & ovf_i) | ((mode_i == TRIG_BOTH) & match_i);
  assign idle    = ~run_i | ~use_ovf;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else if (srst_i) begin
      lvl_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= ~idle & fire & ~toggle_i;
      if (idle)                lvl_q <= dflt_i;
      else if (fire & toggle_i) lvl_q <= ~lvl_q;
    end
  end

  // pulse inverts the resting level for one cycle
  assign pin_o = lvl_q ^ pulse_q;

  p_idle_level_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!srst_i && idle) |=> lvl_q == $past(dflt_i));
  p_toggle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!srst_i && !idle && fire && toggle_i) |=> lvl_q != $past(lvl_q));
endmodule

// File: rtl/cmp_timer_irq.sv
`timescale 1ns/1ps
module cmp_timer_irq #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         srst_i,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] ien_i,
  input  logic [N-1:0] wen_i,
  input  logic         clr_i,
  input  logic [N-1:0] clr_mask_i,
  output logic [N-1:0] status_o,
  output logic         irq_o,
  output logic         wake_o
);
  logic [N-1:0] stat_q, keep;
  logic         wake_q;

  assign keep = clr_i ? ~clr_mask_i : '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      wake_q <= 1'b0;
    end else if (srst_i) begin
      stat_q <= '0;
      wake_q <= 1'b0;
    end else begin
      stat_q <= (stat_q & keep) | (evt_i & ien_i);
      wake_q <= |(evt_i & wen_i);
    end
  end

  assign status_o = stat_q;
  assign irq_o    = |stat_q;
  assign wake_o   = wake_q;

  p_set_raises_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!srst_i && |(evt_i & ien_i)) |=> irq_o);
  p_masked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!srst_i && !irq_o && (evt_i & ien_i) == '0) |=> !irq_o);
  p_wake_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!srst_i && |(evt_i & wen_i)) |=> wake_o);
  p_wake_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((evt_i & wen_i) == '0) |=> !wake_o);
endmodule

// File: rtl/cmp_timer.sv
`timescale 1ns/1ps
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int          DW     = 32,
  parameter int          PS_W   = 3,
  parameter logic [31:0] ID_VAL = 32'h21,
  parameter logic [31:0] CFG_MASK = 32'h33D
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [3:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          cap_evt_i,
  output logic          irq_o,
  output logic          wake_o,
  output logic          pin_o,
  output logic          pin_oe_o
);
  ctrl_t            ctrl_q;
  logic [DW-1:0]    cfg_q, load_q, match_q, cnt;
  logic [N_EV-1:0]  ien_q, wen_q, status, evt;
  logic             posted_q, srst, wr_cnt, wr_trig, tick, ovf, mat;

  assign srst    = we_i && addr_i == A_CFG && wdata_i[1];
  assign wr_cnt  = we_i && addr_i == A_CNT;
  assign wr_trig = we_i && addr_i == A_TRIG;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0; cfg_q <= '0; load_q <= '0; match_q <= '0;
      ien_q <= '0; wen_q <= '0; posted_q <= 1'b1;
    end else if (srst) begin
      ctrl_q <= '0; cfg_q <= '0; load_q <= '0; match_q <= '0;
      ien_q <= '0; wen_q <= '0; posted_q <= 1'b1;
    end else begin
      if (we_i) begin
        case (addr_i)
          A_CFG:   cfg_q    <= wdata_i & CFG_MASK;
          A_IEN:   ien_q    <= wdata_i[N_EV-1:0];
          A_WEN:   wen_q    <= wdata_i[N_EV-1:0];
          A_LOAD:  load_q   <= wdata_i;
          A_MATCH: match_q  <= wdata_i;
          A_POST:  posted_q <= wdata_i[2];
          default: ;
        endcase
      end
      if (we_i && addr_i == A_CTRL) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      else if (ovf && !ctrl_q.reload) ctrl_q.run <= 1'b0;
    end
  end

  cmp_timer_presc #(.PS_W(PS_W)) u_presc (
    .clk_i, .rst_ni, .srst_i(srst), .run_i(ctrl_q.run),
    .en_i(ctrl_q.pre_en), .sel_i(ctrl_q.pre_val), .tick_o(tick)
  );

  cmp_timer_cnt #(.W(DW)) u_cnt (
    .clk_i, .rst_ni, .srst_i(srst), .tick_i(tick),
    .reload_en_i(ctrl_q.reload), .cmp_en_i(ctrl_q.cmp_en),
    .wr_i(wr_cnt), .wr_val_i(wdata_i), .trig_i(wr_trig),
    .load_i(load_q), .match_i(match_q),
    .cnt_o(cnt), .ovf_o(ovf), .match_o(mat)
  );

  cmp_timer_pin u_pin (
    .clk_i, .rst_ni, .srst_i(srst), .run_i(ctrl_q.run),
    .mode_i(ctrl_q.trig), .toggle_i(ctrl_q.toggle), .dflt_i(ctrl_q.dflt),
    .ovf_i(ovf), .match_i(mat), .pin_o
  );

  always_comb begin
    evt         = '0;
    evt[EV_MAT] = mat;
    evt[EV_OVF] = ovf;
    evt[EV_CAP] = cap_evt_i;
  end

  cmp_timer_irq #(.N(N_EV)) u_irq (
    .clk_i, .rst_ni, .srst_i(srst), .evt_i(evt), .ien_i(ien_q),
    .wen_i(wen_q), .clr_i(we_i && addr_i == A_STAT),
    .clr_mask_i(wdata_i[N_EV-1:0]), .status_o(status), .irq_o, .wake_o
  );

  assign pin_oe_o = ~ctrl_q.pin_in;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_ID:    rdata_o = ID_VAL;
      A_CFG:   rdata_o = cfg_q;
      A_RSTS:  rdata_o = DW'(1);
      A_STAT:  rdata_o = DW'(status);
      A_IEN:   rdata_o = DW'(ien_q);
      A_WEN:   rdata_o = DW'(wen_q);
      A_CTRL:  rdata_o = DW'(ctrl_q);
      A_CNT:   rdata_o = cnt;
      A_LOAD:  rdata_o = load_q;
      A_TRIG:  rdata_o = '1;
      A_MATCH: rdata_o = match_q;
      A_POST:  rdata_o = DW'({posted_q, 2'b00});
      default: rdata_o = '0;
    endcase
  end

  p_stop_on_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf && !ctrl_q.reload && !we_i) |=> !ctrl_q.run);
  p_soft_reset_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst |=> (ctrl_q == '0 && posted_q && !irq_o));
endmodule

// File: tb/cmp_timer_test.sv
`timescale 1ns/1ps
module cmp_timer_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        cap_evt_i = 1'b0;
  logic        irq_o, wake_o, pin_o, pin_oe_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  cmp_timer uut (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .rdata_o,
    .cap_evt_i, .irq_o, .wake_o, .pin_o, .pin_oe_o
  );

  localparam logic [3:0] ID = 4'h0, CFG = 4'h1, RSTS = 4'h2, STAT = 4'h3,
    IEN = 4'h4, WEN = 4'h5, CTRL = 4'h6, CNT = 4'h7, LOAD = 4'h8,
    TRIG = 4'h9, MATCH = 4'hA, POST = 4'hB;

  function automatic logic [31:0] exp_count(int k, bit pre, int v);
    return pre ? 32'(k >> (v + 1)) : 32'(k);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called in low phase; returns in the low phase after the write edge
  task automatic wr(logic [3:0] a, logic [31:0] d);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    addr_i = a;
    #0.5;
    d = rdata_o;
  endtask

  task automatic edges(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic chk_reg(string tag, logic [3:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    edges(3);
    rst_ni = 1'b1;
    edges(1);

    // R1 reset state
    chk_reg("R1 id", ID, 32'h21);
    chk_reg("R1 rststat", RSTS, 32'h1);
    chk_reg("R1 trig", TRIG, 32'hFFFF_FFFF);
    chk_reg("R1 posted", POST, 32'h4);
    chk_reg("R1 ctrl", CTRL, 0);
    chk_reg("R1 count", CNT, 0);
    chk_reg("R1 status", STAT, 0);
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 pin", 32'(pin_o), 0);
    chk("R1 oe", 32'(pin_oe_o), 1);

    // R11 config mask and soft reset
    wr(CFG, 32'hFFFF_FFFD);
    chk_reg("R11 mask", CFG, 32'h33D);
    wr(LOAD, 32'h55); wr(POST, 0); wr(IEN, 7);
    chk_reg("R11 posted written", POST, 0);
    wr(CFG, 32'h2);
    chk_reg("R11 cfg", CFG, 0);
    chk_reg("R11 load", LOAD, 0);
    chk_reg("R11 ien", IEN, 0);
    chk_reg("R11 posted", POST, 32'h4);

    // R2 counting, R12 write at the top of range
    wr(IEN, 2);
    wr(CNT, 32'hFFFF_FFF0);
    wr(CTRL, 1);
    edges(5);
    chk_reg("R2 count", CNT, 32'hFFFF_FFF5);
    edges(10);
    chk_reg("R2 top", CNT, 32'hFFFF_FFFF);
    wr(CNT, 100);
    chk_reg("R12 count", CNT, 100);
    chk_reg("R12 status", STAT, 0);
    chk_reg("R12 run", CTRL, 1);
    edges(2);
    chk_reg("R2 resume", CNT, 102);

    // R4 wrap without reload
    wr(CNT, 32'hFFFF_FFFD);
    edges(3);
    chk_reg("R4 status", STAT, 2);
    chk("R8 irq", 32'(irq_o), 1);
    chk_reg("R4 stopped", CTRL, 0);
    chk_reg("R4 zero", CNT, 0);
    edges(2);
    chk_reg("R4 held", CNT, 0);
    wr(STAT, 2);
    chk_reg("R8 clear", STAT, 0);
    chk("R8 irq low", 32'(irq_o), 0);

    // R4 wrap with reload
    wr(LOAD, 32'h1000);
    wr(CNT, 32'hFFFF_FFFE);
    wr(CTRL, 3);
    edges(2);
    chk_reg("R4 reload", CNT, 32'h1000);
    chk_reg("R4 still running", CTRL, 3);
    edges(3);
    chk_reg("R4 after reload", CNT, 32'h1003);
    wr(CTRL, 0);

    // R10 trigger register
    wr(LOAD, 32'hABC);
    wr(CNT, 5);
    wr(TRIG, 0);
    chk_reg("R10 count", CNT, 32'hABC);

    // R5/R8/R9 match with masks
    wr(STAT, 7);
    wr(IEN, 1);
    wr(WEN, 2);
    wr(MATCH, 32'h20);
    wr(CNT, 32'h1D);
    wr(CTRL, 32'h41);
    edges(3);
    chk_reg("R5 match status", STAT, 1);
    chk("R8 irq match", 32'(irq_o), 1);
    chk("R9 no wake", 32'(wake_o), 0);
    wr(STAT, 1);
    wr(CNT, 32'hFFFF_FFFD);
    edges(3);
    chk("R9 wake", 32'(wake_o), 1);
    chk_reg("R8 masked ovf", STAT, 0);
    edges(1);
    chk("R9 wake one cycle", 32'(wake_o), 0);

    // R6 toggle on overflow and match
    wr(STAT, 7);
    wr(LOAD, 0);
    wr(MATCH, 5);
    wr(CNT, 32'hFFFF_FFFD);
    chk("R7 idle pin", 32'(pin_o), 0);
    wr(CTRL, 32'h1843);
    edges(3);
    chk("R6 toggle ovf", 32'(pin_o), 1);
    edges(4);
    chk("R6 hold", 32'(pin_o), 1);
    edges(1);
    chk("R6 toggle match", 32'(pin_o), 0);

    // R7 default level and direction
    wr(CTRL, 32'h80);
    edges(1);
    chk("R7 default", 32'(pin_o), 1);
    chk("R7 oe out", 32'(pin_oe_o), 1);
    wr(CTRL, 32'h4080);
    chk("R7 oe in", 32'(pin_oe_o), 0);

    // R6 pulse on overflow
    wr(CNT, 32'hFFFF_FFFD);
    wr(CTRL, 32'h483);
    edges(3);
    chk("R6 pulse", 32'(pin_o), 0);
    edges(1);
    chk("R6 pulse end", 32'(pin_o), 1);
    wr(CTRL, 0);

    // R3 random prescaler settings
    for (int i = 0; i < 20; i++) begin
      bit pre;
      int v, k;
      pre = 1'($urandom_range(0, 1));
      v   = int'($urandom_range(0, 7));
      k   = int'($urandom_range(1, 400));
      wr(CTRL, 0);
      wr(CNT, 0);
      wr(CTRL, 32'(1 | (int'(pre) << 5) | (v << 2)));
      edges(k);
      chk_reg("R3 prescale", CNT, exp_count(k, pre, v));
    end
    wr(CTRL, 0);

    // R8/R9 random masks on overflow and capture
    for (int i = 0; i < 12; i++) begin
      logic [2:0] ie, we;
      ie = 3'($urandom_range(0, 7));
      we = 3'($urandom_range(0, 7));
      wr(STAT, 7);
      wr(IEN, 32'(ie));
      wr(WEN, 32'(we));
      if (i % 2 == 0) begin
        wr(CNT, 32'hFFFF_FFFD);
        wr(CTRL, 1);
        edges(3);
        chk_reg("R8 rand ovf", STAT, 32'(ie & 3'b010));
        chk("R9 rand ovf", 32'(wake_o), 32'(we[1]));
      end else begin
        cap_evt_i = 1'b1;
        edges(1);
        cap_evt_i = 1'b0;
        chk_reg("R8 rand cap", STAT, 32'(ie & 3'b100));
        chk("R9 rand cap", 32'(wake_o), 32'(we[2]));
      end
      chk("R8 rand irq", 32'(irq_o), 32'(|(ie & (i % 2 == 0 ? 3'b010 : 3'b100))));
    end

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule